// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit forms the memory address for a load or store. From a base register value, an index register value, a scale code, a signed 16-bit immediate, the program counter, an operand size and a mode code, it computes the effective address. In the auto-modify modes it also computes a new value for the base register, along with an enable that tells the register file to write that value back. A stack push is expressed as a pre-decrement of the stack pointer, and a stack pop as a post-increment.

The result leaves through a single output register with one cycle of latency, under a valid/ready handshake on both sides. Two cases are reported through an error flag: a mode code with no meaning, and an operand size code with no meaning in an auto-modify mode. In either case the address is zero and no write-back takes place. All additions wrap modulo 2^32.

Top module: `agu_top`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid_o` is 0 until the first input is accepted.
- R2: Mode 0 (register indirect) gives an address equal to `base_i`.
- R3: Mode 1 gives `base_i` plus `imm_i`, with `imm_i` sign-extended from 16 to 32 bits. The sum wraps modulo 2^32.
- R4: The base is never shifted. The index is shifted left by `scale_i` (0 to 3 bits, a factor of 1, 2, 4 or 8). Mode 2 gives base plus scaled index. Mode 3 gives base plus scaled index plus the sign-extended immediate.
- R5: Mode 4 gives `pc_i` plus the sign-extended immediate.
- R6: Mode 5 (pre-decrement, push) sets both the address and the write-back value to `base_i` minus the step. The step is 1, 2 or 4 for `size_i` codes 0, 1 and 2.
- R7: Mode 6 (post-increment, pop) sets the address to `base_i` unchanged and the write-back value to `base_i` plus the step.
- R8: `wb_en_o` is 1 only for a valid result in mode 5 or 6. In every other mode it is 0 and `wb_data_o` is 0.
- R9: Mode code 7, or `size_i` code 3 in mode 5 or 6, sets `err_o` to 1, `addr_o` to 0 and `wb_en_o` to 0. In every other case `err_o` is 0.
- R10: `in_ready_o` is 1 when the output register is empty or `out_ready_i` is 1. An accepted input appears at the output one cycle later. While `out_valid_o` is 1 and `out_ready_i` is 0, the outputs hold steady and no input is taken.
- R11: Inputs that a mode does not use have no effect on its result: the index and scale outside modes 2 and 3, the immediate outside modes 1, 3 and 4, `pc_i` outside mode 4, and `size_i` outside modes 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Unit can take a request |
| mode_i | input | 3 | Addressing mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| scale_i | input | 2 | Left shift applied to the index |
| imm_i | input | 16 | Signed immediate offset |
| pc_i | input | 32 | Program counter |
| size_i | input | 2 | Operand size code (0 byte, 1 half, 2 word) |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_data_o | output | 32 | Base register write-back value |
| err_o | output | 1 | Undefined mode or size |

## Verification
The unit holds state only in its output register and valid bit. A wrong value there shows up at the ports in the cycle right after the accepting edge, as a bad address, write-back or flag. A fault in the valid or hold logic shows up as a result that is lost, duplicated or changes while stalled, and it appears within one or two cycles of a stall. Errors in the step table, the sign extension or the scale selection stay hidden until a matching size, a negative immediate or a nonzero scale is presented. For that reason, wrap-around and extreme-offset cases are driven directly, alongside random stimulus across all mode and size codes.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam logic [2:0] MODE_REG     = 3'd0;
  localparam logic [2:0] MODE_BOFF    = 3'd1;
  localparam logic [2:0] MODE_BIDX    = 3'd2;
  localparam logic [2:0] MODE_BIDXOFF = 3'd3;
  localparam logic [2:0] MODE_PCREL   = 3'd4;
  localparam logic [2:0] MODE_PREDEC  = 3'd5;
  localparam logic [2:0] MODE_POSTINC = 3'd6;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/agu_scale.sv
module agu_scale #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 2
) (
  input  logic [AW-1:0] idx_i,
  input  logic [SW-1:0] scale_i,
  output logic [AW-1:0] scaled_o
);
  localparam int unsigned NSH = 1 << SW;

  logic [AW-1:0] shv [NSH];

  for (genvar s = 0; s < NSH; s++) begin : g_sh
    assign shv[s] = idx_i << s;
  end

  assign scaled_o = shv[scale_i];
endmodule

// File: rtl/agu_step.sv
module agu_step #(
  parameter int unsigned AW = 32
) (
  input  logic [1:0]    size_i,
  output logic [AW-1:0] step_o,
  output logic          ok_o
);
  import agu_pkg::*;

  always_comb begin
    ok_o   = 1'b1;
    step_o = '0;
    case (size_i)
      SZ_BYTE: step_o = AW'(1);
      SZ_HALF: step_o = AW'(2);
      SZ_WORD: step_o = AW'(4);
      default: ok_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 16,
  parameter int unsigned SW = 2
) (
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [SW-1:0] scale_i,
  input  logic [IW-1:0] imm_i,
  input  logic [AW-1:0] pc_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_data_o,
  output logic          err_o
);
  import agu_pkg::*;

  logic [AW-1:0] imm_sx, scaled, step;
  logic          step_ok;

  assign imm_sx = {{(AW-IW){imm_i[IW-1]}}, imm_i};

  agu_scale #(.AW(AW), .SW(SW)) u_scale (
    .idx_i(index_i), .scale_i(scale_i), .scaled_o(scaled)
  );

  agu_step #(.AW(AW)) u_step (
    .size_i(size_i), .step_o(step), .ok_o(step_ok)
  );

  always_comb begin
    addr_o    = '0;
    wb_en_o   = 1'b0;
    wb_data_o = '0;
    err_o     = 1'b0;
    case (mode_i)
      MODE_REG:     addr_o = base_i;
      MODE_BOFF:    addr_o = base_i + imm_sx;
      MODE_BIDX:    addr_o = base_i + scaled;
      MODE_BIDXOFF: addr_o = base_i + scaled + imm_sx;
      MODE_PCREL:   addr_o = pc_i + imm_sx;
      MODE_PREDEC: begin
        if (step_ok) begin
          addr_o    = base_i - step;
          wb_data_o = base_i - step;
          wb_en_o   = 1'b1;
        end else begin
          err_o = 1'b1;
        end
      end
      MODE_POSTINC: begin
        if (step_ok) begin
          addr_o    = base_i;
          wb_data_o = base_i + step;
          wb_en_o   = 1'b1;
        end else begin
          err_o = 1'b1;
        end
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 16,
  parameter int unsigned SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [SW-1:0] scale_i,
  input  logic [IW-1:0] imm_i,
  input  logic [AW-1:0] pc_i,
  input  logic [1:0]    size_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_data_o,
  output logic          err_o
);
  logic [AW-1:0] c_addr, c_wb;
  logic          c_wb_en, c_err;
  logic          accept;

  agu_calc #(.AW(AW), .IW(IW), .SW(SW)) u_calc (
    .mode_i(mode_i), .base_i(base_i), .index_i(index_i), .scale_i(scale_i),
    .imm_i(imm_i), .pc_i(pc_i), .size_i(size_i),
    .addr_o(c_addr), .wb_en_o(c_wb_en), .wb_data_o(c_wb), .err_o(c_err)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      addr_o      <= '0;
      wb_en_o     <= 1'b0;
      wb_data_o   <= '0;
      err_o       <= 1'b0;
    end else begin
      if (accept) begin
        out_valid_o <= 1'b1;
        addr_o      <= c_addr;
        wb_en_o     <= c_wb_en;
        wb_data_o   <= c_wb;
        err_o       <= c_err;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/agu_top_chk.sv
module agu_top_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [2:0]    mode_i,
  input logic [AW-1:0] base_i,
  input logic [1:0]    size_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [AW-1:0] addr_o,
  input logic          wb_en_o,
  input logic [AW-1:0] wb_data_o,
  input logic          err_o
);
  // R10
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(addr_o) && $stable(wb_data_o) && $stable(wb_en_o) && $stable(err_o)));

  // R7
  postinc_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && mode_i == 3'd6 && size_i != 2'd3) |=>
      (addr_o == $past(base_i) && wb_en_o));

  // R6 R7
  wb_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && wb_en_o) |->
      (wb_data_o == addr_o || (wb_data_o - addr_o) == AW'(1) ||
       (wb_data_o - addr_o) == AW'(2) || (wb_data_o - addr_o) == AW'(4)));

  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && err_o) |-> (addr_o == '0 && !wb_en_o));

  // R8
  wb_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && mode_i < 3'd5) |=> (!wb_en_o && wb_data_o == '0));
endmodule

bind agu_top agu_top_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .mode_i(mode_i), .base_i(base_i), .size_i(size_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .addr_o(addr_o), .wb_en_o(wb_en_o),
  .wb_data_o(wb_data_o), .err_o(err_o)
);

// File: tb/agu_top_bench.sv
`timescale 1ns/1ps
module agu_top_bench;
  localparam int unsigned AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [2:0] mode = '0;
  logic [AW-1:0] base = '0, index = '0, pc = '0;
  logic [1:0] scale = '0, size = '0;
  logic [15:0] imm = '0;
  logic [AW-1:0] addr, wb_data;
  logic wb_en, err;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  agu_top u_agu_top (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .mode_i(mode), .base_i(base), .index_i(index), .scale_i(scale), .imm_i(imm),
    .pc_i(pc), .size_i(size), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .addr_o(addr), .wb_en_o(wb_en), .wb_data_o(wb_data), .err_o(err)
  );

  function automatic logic [2*AW+1:0] model(input logic [2:0] m, input logic [AW-1:0] b,
      input logic [AW-1:0] x, input logic [1:0] sc, input logic [15:0] im,
      input logic [AW-1:0] p, input logic [1:0] sz);
    logic [AW-1:0] sx, st, a, w;
    logic e, we;
    sx = {{(AW-16){im[15]}}, im};
    st = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    a = '0; w = '0; e = 0; we = 0;
    case (m)
      3'd0: a = b;
      3'd1: a = b + sx;
      3'd2: a = b + (x << sc);
      3'd3: a = b + (x << sc) + sx;
      3'd4: a = p + sx;
      3'd5: if (sz == 2'd3) e = 1; else begin a = b - st; w = a; we = 1; end
      3'd6: if (sz == 2'd3) e = 1; else begin a = b; w = b + st; we = 1; end
      default: e = 1;
    endcase
    return {e, we, w, a};
  endfunction

  task automatic check(input string req, input logic [2*AW+1:0] act, input logic [2*AW+1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [2:0] m, input logic [AW-1:0] b, input logic [AW-1:0] x,
      input logic [1:0] sc, input logic [15:0] im, input logic [AW-1:0] p, input logic [1:0] sz);
    mode = m; base = b; index = x; scale = sc; imm = im; pc = p; size = sz;
  endtask

  function automatic logic [2*AW+1:0] outs();
    return {err, wb_en, wb_data, addr};
  endfunction

  // drive at negedge, accept at posedge, check at next negedge
  task automatic send(input string req, input logic [2:0] m, input logic [AW-1:0] b,
      input logic [AW-1:0] x, input logic [1:0] sc, input logic [15:0] im,
      input logic [AW-1:0] p, input logic [1:0] sz);
    logic [2*AW+1:0] exp;
    set_in(m, b, x, sc, im, p, sz);
    exp = model(m, b, x, sc, im, p, sz);
    in_valid = 1; out_ready = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {{(2*AW+1){1'b0}}, out_valid}, {{(2*AW+1){1'b0}}, 1'b1});
    check(req, outs(), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [2*AW+1:0] t1;
    logic [2*AW+1:0] t2;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", {{(2*AW+1){1'b0}}, out_valid}, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {{(2*AW){1'b0}}, out_valid, in_ready}, {{(2*AW){1'b0}}, 2'b01});

    send("R2 reg", 3'd0, 32'h1234_5678, 32'hFFFF_FFFF, 2'd3, 16'h7FFF, 32'h1, 2'd1);
    send("R3 neg", 3'd1, 32'h0, 32'h0, 2'd0, 16'h8000, 32'h0, 2'd0);
    send("R3 wrap", 3'd1, 32'hFFFF_FFF0, 32'h0, 2'd0, 16'h0020, 32'h0, 2'd0);
    send("R4 scale8", 3'd2, 32'h100, 32'h2000_0001, 2'd3, 16'h0, 32'h0, 2'd0);
    send("R4 idx+off", 3'd3, 32'h1000, 32'h10, 2'd2, 16'hFFFC, 32'h0, 2'd0);
    send("R5 pcrel", 3'd4, 32'hDEAD, 32'h5, 2'd1, 16'hFF00, 32'h8000_0000, 2'd2);
    send("R6 push word wrap", 3'd5, 32'h0, 32'h0, 2'd0, 16'h0, 32'h0, 2'd2);
    send("R6 push byte", 3'd5, 32'h100, 32'h0, 2'd0, 16'h0, 32'h0, 2'd0);
    send("R7 pop half", 3'd6, 32'h200, 32'h0, 2'd0, 16'h0, 32'h0, 2'd1);
    send("R9 mode7", 3'd7, 32'h55, 32'h1, 2'd1, 16'h1, 32'h1, 2'd0);
    send("R9 size3", 3'd6, 32'h55, 32'h1, 2'd1, 16'h1, 32'h1, 2'd3);
    send("R8 no wb", 3'd3, 32'h55, 32'h1, 2'd1, 16'h1, 32'h1, 2'd2);
    // R11 unused inputs toggled
    send("R11 unused", 3'd0, 32'hCAFE_0000, 32'h1234, 2'd2, 16'h8001, 32'h9999, 2'd3);

    @(posedge clk); @(negedge clk);
    check("R10 drains", {{(2*AW+1){1'b0}}, out_valid}, '0);

    // R10 stall
    set_in(3'd1, 32'h4000, 32'h0, 2'd0, 16'h0004, 32'h0, 2'd0);
    t1 = model(3'd1, 32'h4000, 32'h0, 2'd0, 16'h0004, 32'h0, 2'd0);
    in_valid = 1; out_ready = 0;
    @(posedge clk); @(negedge clk);
    set_in(3'd6, 32'h8000, 32'h0, 2'd0, 16'h0, 32'h0, 2'd2);
    t2 = model(3'd6, 32'h8000, 32'h0, 2'd0, 16'h0, 32'h0, 2'd2);
    check("R10 stall out", outs(), t1);
    check("R10 stall ready", {{(2*AW){1'b0}}, out_valid, in_ready}, {{(2*AW){1'b0}}, 2'b10});
    @(posedge clk); @(negedge clk);
    check("R10 hold", outs(), t1);
    check("R10 hold valid", {{(2*AW+1){1'b0}}, out_valid}, {{(2*AW+1){1'b0}}, 1'b1});
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    check("R10 pass", outs(), t2);
    @(posedge clk); @(negedge clk);
    check("R10 empty", {{(2*AW+1){1'b0}}, out_valid}, '0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      send("R2-R9 rand", 3'($urandom_range(0, 7)), $urandom, $urandom,
           2'($urandom_range(0, 3)), 16'($urandom), $urandom, 2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule